// File: doc/BRIEF.md
# Channel-Buffered DRAM Command Spacing Guard

This block sits between a memory controller's command issuer and a two-bank DRAM that keeps row data in a set of channel buffers. Each clock the issuer offers one command on a valid/ready handshake. The command is an activate, a precharge, a refresh, one of three prefetch kinds (plain, with auto-precharge, or for read), one of two restore kinds (plain or with auto-precharge), or a foreground read or write. Every command carries a bank number and a channel number. The guard holds `cmd_ready` low until every minimum spacing that applies to the command has elapsed. It then accepts the command and presents it on a registered issue port one clock later.

The guard tracks whether each bank is open. It marks an activate that closes a restore window as a restore-activate, and it opens a short window after each restore. Inside that window it rejects other background traffic and any foreground access to the channel being restored. Commands that are illegal for the current state are accepted and dropped, and each drop raises a one-clock error pulse. A second flag reports a bank that has stayed open longer than its maximum open time. All spacings are whole clocks for a 7.5 ns clock.

Top module: `vc_cmd_guard`

## Requirements
- R1: While `rst` is high, `cmd_ready` is low. After reset both banks are idle, all spacings are met, `iss_valid`, `err_illegal` and `err_open_long` are low, and an activate to either bank issues in the first cycle it is offered.
- R2: Op codes are ACT=0, PRE=1, REF=2, PFC=3, PFCA=4, PFR=5, RST=6, RSTA=7, RD=8, WR=9. Codes 10 to 15 are accepted, never issued, and pulse `err_illegal`.
- R3: A command accepted in cycle t appears on `iss_valid/iss_op/iss_bank/iss_chan` in cycle t+1. While any applicable spacing is unmet, `cmd_ready` stays low and the command waits.
- R4: Same bank, counted in clocks between issues: ACT or REF to the next ACT or REF is at least 9, PRE to ACT or REF is at least 3, and PFCA or PFR to ACT or REF is at least 6. PFCA and PFR close the bank.
- R5: Same bank: ACT to PRE is at least 7, and PFC to PRE is at least 3.
- R6: ACT to PFC, PFCA or PFR on the same bank is at least 2. A restore-activate to any PFC, PFCA or PFR is at least 5. PFC to a later PFC or PFCA is at least 3.
- R7: ACT to ACT, across banks or restore-activate or not, is at least 2. Restore-activate to restore-activate is at least 4. PFC or PFCA to RST or RSTA is at least 3.
- R8: After RST or RSTA to an idle bank, an ACT to that bank in the next 1 to 4 clocks issues with `iss_ract` high. If none issues by the 4th clock, `err_illegal` pulses once, one clock after that 4th clock, and a later ACT is a plain activate.
- R9: While a restore window is open, a background command other than the ACT to the restored bank is dropped with an error, and so is a RD or WR to the restored channel.
- R10: RD or WR after a RD or WR needs 1 clock. After PFC or PFCA on the same channel it needs 2 clocks, and after a restore-activate for the same channel it needs 4 clocks. Other channels are not delayed.
- R11: ACT, REF, RST or RSTA to an open bank, and PRE, PFC, PFCA or PFR to an idle bank, are dropped with a one-clock `err_illegal` pulse.
- R12: `err_open_long` goes high T_RAS_MAX+1 clocks after the activate while the bank is still open, one clock later through its register. It falls two clocks after the closing command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Candidate command present |
| cmd_op | input | 4 | Command code (R2) |
| cmd_bank | input | BW | Target bank |
| cmd_chan | input | CHW | Channel buffer number |
| cmd_ready | output | 1 | Command accepted this clock (issued or dropped) |
| iss_valid | output | 1 | Registered issued-command strobe |
| iss_op | output | 4 | Issued command code |
| iss_bank | output | BW | Issued bank |
| iss_chan | output | CHW | Issued channel |
| iss_ract | output | 1 | Issued ACT is a restore-activate |
| err_illegal | output | 1 | One-clock pulse on a dropped command or an expired restore window |
| err_open_long | output | 1 | Some bank has been open beyond its maximum time |

## Verification
The in-line properties check several rules on every clock. They check that ready stays low in reset, that every issue traces back to an accepted handshake, and that a restore-activate flag only ever comes with an activate. They also check that two activates never issue on adjacent clocks, that a precharge never directly follows an activate on the same bank, and that unknown codes always end in a drop. Only the bench scenarios can show the exact stall lengths for each spacing rule, the boundary clock at which a spacing is met, and the restore window opening, closing and expiring. The same holds for independence across channels and the clock at which the open-time flag rises.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

  typedef enum logic [3:0] {
    OP_ACT  = 4'd0,
    OP_PRE  = 4'd1,
    OP_REF  = 4'd2,
    OP_PFC  = 4'd3,
    OP_PFCA = 4'd4,
    OP_PFR  = 4'd5,
    OP_RST  = 4'd6,
    OP_RSTA = 4'd7,
    OP_RD   = 4'd8,
    OP_WR   = 4'd9
  } vcg_op_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vcg_cnt.sv
// Spacing down-counter: reloads to the larger of the pending and new count.
module vcg_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  output logic          zero
);

  logic [CW-1:0] val;
  logic [CW-1:0] dec;

  assign dec  = (val == '0) ? '0 : val - 1'b1;
  assign zero = (val == '0);

  always_ff @(posedge clk) begin
    if (rst)                      val <= '0;
    else if (load && ld_val > dec) val <= ld_val;
    else                          val <= dec;
  end

  // R4: a reload never leaves less time pending than was asked for
  a_r4_load_floor: assert property (@(posedge clk) disable iff (rst)
    load |=> (val >= $past(ld_val)));

endmodule

// File: rtl/vcg_bank.sv
// Per-bank open state, same-bank spacing counters and open-time tracking.
module vcg_bank
  import vcg_pkg::*;
#(
  parameter int T_RC      = 9,
  parameter int T_RAS     = 7,
  parameter int T_RAS_MAX = 16000,
  parameter int T_RP      = 3,
  parameter int T_APD     = 2,
  parameter int T_PPL     = 3,
  parameter int T_PAL     = 6,
  parameter int CW        = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       iss,
  input  logic [3:0] op,
  output logic       active,
  output logic       ok_actref,
  output logic       ok_pre,
  output logic       ok_pf,
  output logic       open_long
);

  localparam int OW = $clog2(T_RAS_MAX + 1);
  localparam logic [OW-1:0] OPEN_SAT = OW'(T_RAS_MAX);

  vcg_op_e opc;
  assign opc = vcg_op_e'(op);

  logic          ld_ar, ld_pre, ld_pf;
  logic [CW-1:0] v_ar, v_pre;
  logic [OW-1:0] open_cnt;

  always_comb begin
    ld_ar  = 1'b0;
    v_ar   = '0;
    ld_pre = 1'b0;
    v_pre  = '0;
    case (opc)
      OP_ACT: begin
        ld_ar  = iss;
        v_ar   = CW'(T_RC - 1);
        ld_pre = iss;
        v_pre  = CW'(T_RAS - 1);
      end
      OP_REF: begin
        ld_ar = iss;
        v_ar  = CW'(T_RC - 1);
      end
      OP_PRE: begin
        ld_ar = iss;
        v_ar  = CW'(T_RP - 1);
      end
      OP_PFCA, OP_PFR: begin
        ld_ar = iss;
        v_ar  = CW'(T_PAL - 1);
      end
      OP_PFC: begin
        ld_pre = iss;
        v_pre  = CW'(T_PPL - 1);
      end
      default: ;
    endcase
  end

  assign ld_pf = iss && (opc == OP_ACT);

  vcg_cnt #(.CW(CW)) u_ar (
    .clk(clk), .rst(rst), .load(ld_ar), .ld_val(v_ar), .zero(ok_actref));
  vcg_cnt #(.CW(CW)) u_pre (
    .clk(clk), .rst(rst), .load(ld_pre), .ld_val(v_pre), .zero(ok_pre));
  vcg_cnt #(.CW(CW)) u_pf (
    .clk(clk), .rst(rst), .load(ld_pf), .ld_val(CW'(T_APD - 1)), .zero(ok_pf));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (iss) begin
      if (opc == OP_ACT) active <= 1'b1;
      else if (opc == OP_PRE || opc == OP_PFCA || opc == OP_PFR) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             open_cnt <= '0;
    else if (iss && opc == OP_ACT)       open_cnt <= '0;
    else if (active && open_cnt != OPEN_SAT) open_cnt <= open_cnt + 1'b1;
  end

  assign open_long = active && (open_cnt >= OPEN_SAT);

  // R11: an activate is only ever issued to an idle bank
  a_r11_act_on_idle: assert property (@(posedge clk) disable iff (rst)
    (iss && opc == OP_ACT) |-> !active);

  // R5: a precharge never lands on the clock right after an activate
  if (T_RAS >= 2) begin : g_ras_chk
    a_r5_pre_not_after_act: assert property (@(posedge clk) disable iff (rst)
      (iss && opc == OP_PRE) |-> !$past(iss && opc == OP_ACT));
  end

  // R12: the open-time flag can only rise on a bank that was already open
  a_r12_flag_needs_open: assert property (@(posedge clk) disable iff (rst)
    $rose(open_long) |-> $past(active));

endmodule

// File: rtl/vc_cmd_guard.sv
module vc_cmd_guard
  import vcg_pkg::*;
#(
  parameter int BW        = 1,
  parameter int CHW       = 4,
  parameter int T_RC      = 9,
  parameter int T_RAS     = 7,
  parameter int T_RAS_MAX = 16000,
  parameter int T_RP      = 3,
  parameter int T_APD     = 2,
  parameter int T_PPL     = 3,
  parameter int T_PAL     = 6,
  parameter int T_RAD_MAX = 4,
  parameter int T_RPD     = 5,
  parameter int T_PPD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RRDR    = 4,
  parameter int T_PRD     = 3,
  parameter int T_CCD     = 1,
  parameter int T_PCD     = 2,
  parameter int T_RCD     = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [BW-1:0]  cmd_bank,
  input  logic [CHW-1:0] cmd_chan,
  output logic           cmd_ready,
  output logic           iss_valid,
  output logic [3:0]     iss_op,
  output logic [BW-1:0]  iss_bank,
  output logic [CHW-1:0] iss_chan,
  output logic           iss_ract,
  output logic           err_illegal,
  output logic           err_open_long
);

  localparam int NB   = 2 ** BW;
  localparam int NCH  = 2 ** CHW;
  localparam int TMAX = max2(max2(T_RC, T_PAL), max2(T_RPD, T_RCD));
  localparam int CW   = $clog2(TMAX) + 1;
  localparam int WW   = $clog2(T_RAD_MAX + 1);
  localparam logic [WW-1:0] WIN_LEN = WW'(T_RAD_MAX);

  vcg_op_e op;
  assign op = vcg_op_e'(cmd_op);

  logic [NB-1:0]  b_active, b_ok_actref, b_ok_pre, b_ok_pf, b_open_long, b_iss;
  logic [NCH-1:0] fg_ok, fg_load;
  logic           illegal, tim_ok, accept, issue, drop;
  logic           ract_cand, ract_iss, expire;
  logic           actany_z, rr_z, ractpf_z, pfc_z, pfrst_z, rw_z;
  logic [WW-1:0]  win_cnt;
  logic [BW-1:0]  win_bank;
  logic [CHW-1:0] win_chan;
  logic           win_open, bank_open, is_pf_any;
  logic [CW-1:0]  fg_val;

  assign win_open  = (win_cnt != '0);
  assign bank_open = b_active[cmd_bank];
  assign ract_cand = win_open && (op == OP_ACT) && (cmd_bank == win_bank);
  assign is_pf_any = (op == OP_PFC) || (op == OP_PFCA);

  // ---------------- per-bank state ----------------
  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign b_iss[g] = issue && (cmd_bank == BW'(g));
    vcg_bank #(
      .T_RC(T_RC), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP),
      .T_APD(T_APD), .T_PPL(T_PPL), .T_PAL(T_PAL), .CW(CW)
    ) u_bank (
      .clk(clk), .rst(rst), .iss(b_iss[g]), .op(cmd_op),
      .active(b_active[g]), .ok_actref(b_ok_actref[g]), .ok_pre(b_ok_pre[g]),
      .ok_pf(b_ok_pf[g]), .open_long(b_open_long[g])
    );
  end

  // ---------------- per-channel foreground spacing ----------------
  assign fg_val = ract_iss ? CW'(T_RCD - 1) : CW'(T_PCD - 1);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign fg_load[g] = issue && ((is_pf_any && cmd_chan == CHW'(g)) ||
                                  (ract_cand && win_chan == CHW'(g)));
    vcg_cnt #(.CW(CW)) u_fg (
      .clk(clk), .rst(rst), .load(fg_load[g]), .ld_val(fg_val), .zero(fg_ok[g]));
  end

  // ---------------- cross-bank spacing ----------------
  vcg_cnt #(.CW(CW)) u_actany (
    .clk(clk), .rst(rst), .load(issue && op == OP_ACT),
    .ld_val(CW'(T_RRD - 1)), .zero(actany_z));
  vcg_cnt #(.CW(CW)) u_rr (
    .clk(clk), .rst(rst), .load(ract_iss),
    .ld_val(CW'(T_RRDR - 1)), .zero(rr_z));
  vcg_cnt #(.CW(CW)) u_ractpf (
    .clk(clk), .rst(rst), .load(ract_iss),
    .ld_val(CW'(T_RPD - 1)), .zero(ractpf_z));
  vcg_cnt #(.CW(CW)) u_pfc (
    .clk(clk), .rst(rst), .load(issue && op == OP_PFC),
    .ld_val(CW'(T_PPD - 1)), .zero(pfc_z));
  vcg_cnt #(.CW(CW)) u_pfrst (
    .clk(clk), .rst(rst), .load(issue && is_pf_any),
    .ld_val(CW'(T_PRD - 1)), .zero(pfrst_z));
  vcg_cnt #(.CW(CW)) u_rw (
    .clk(clk), .rst(rst), .load(issue && (op == OP_RD || op == OP_WR)),
    .ld_val(CW'(T_CCD - 1)), .zero(rw_z));

  // ---------------- legality and spacing decision ----------------
  always_comb begin
    illegal = 1'b1;
    tim_ok  = 1'b0;
    case (op)
      OP_ACT: begin
        illegal = bank_open || (win_open && !ract_cand);
        tim_ok  = b_ok_actref[cmd_bank] && actany_z && (!ract_cand || rr_z);
      end
      OP_REF: begin
        illegal = bank_open || win_open;
        tim_ok  = b_ok_actref[cmd_bank];
      end
      OP_RST, OP_RSTA: begin
        illegal = bank_open || win_open;
        tim_ok  = pfrst_z;
      end
      OP_PRE: begin
        illegal = !bank_open || win_open;
        tim_ok  = b_ok_pre[cmd_bank];
      end
      OP_PFC, OP_PFCA: begin
        illegal = !bank_open || win_open;
        tim_ok  = b_ok_pf[cmd_bank] && ractpf_z && pfc_z;
      end
      OP_PFR: begin
        illegal = !bank_open || win_open;
        tim_ok  = b_ok_pf[cmd_bank] && ractpf_z;
      end
      OP_RD, OP_WR: begin
        illegal = win_open && (cmd_chan == win_chan);
        tim_ok  = rw_z && fg_ok[cmd_chan];
      end
      default: begin
        illegal = 1'b1;
        tim_ok  = 1'b0;
      end
    endcase
  end

  assign cmd_ready = !rst && (illegal || tim_ok);
  assign accept    = cmd_valid && cmd_ready;
  assign issue     = accept && !illegal;
  assign drop      = accept && illegal;
  assign ract_iss  = issue && ract_cand;
  assign expire    = (win_cnt == WW'(1)) && !ract_iss;

  // ---------------- restore window ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      win_bank <= '0;
      win_chan <= '0;
    end else if (issue && (op == OP_RST || op == OP_RSTA)) begin
      win_cnt  <= WIN_LEN;
      win_bank <= cmd_bank;
      win_chan <= cmd_chan;
    end else if (ract_iss) begin
      win_cnt  <= '0;
    end else if (win_open) begin
      win_cnt  <= win_cnt - 1'b1;
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid     <= 1'b0;
      iss_op        <= '0;
      iss_bank      <= '0;
      iss_chan      <= '0;
      iss_ract      <= 1'b0;
      err_illegal   <= 1'b0;
      err_open_long <= 1'b0;
    end else begin
      iss_valid     <= issue;
      iss_op        <= cmd_op;
      iss_bank      <= cmd_bank;
      iss_chan      <= cmd_chan;
      iss_ract      <= ract_iss;
      err_illegal   <= drop || expire;
      err_open_long <= |b_open_long;
    end
  end

  // R1: nothing is accepted while reset is held
  a_r1_ready_low_in_reset: assert property (@(posedge clk)
    rst |-> !cmd_ready);

  // R3: every issued command traces back to an accepted handshake
  a_r3_issue_from_accept: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(cmd_valid && cmd_ready));

  // R8: the restore-activate flag only accompanies an issued activate
  a_r8_ract_is_act: assert property (@(posedge clk) disable iff (rst)
    iss_ract |-> (iss_valid && iss_op == 4'(OP_ACT)));

  // R8: the restore window never exceeds its length
  a_r8_window_bounded: assert property (@(posedge clk) disable iff (rst)
    win_cnt <= WIN_LEN);

  // R2: unknown codes end in a drop with an error pulse
  a_r2_unknown_dropped: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op > 4'(OP_WR)) |=> (err_illegal && !iss_valid));

  // R7: two activates never issue on adjacent clocks
  if (T_RRD >= 2) begin : g_rrd_chk
    a_r7_act_gap: assert property (@(posedge clk) disable iff (rst)
      (issue && op == OP_ACT) |=> !(issue && op == OP_ACT));
  end

endmodule

// File: tb/sim_vc_cmd_guard.sv
module sim_vc_cmd_guard;

  localparam int CLK_PERIOD = 10;
  localparam int OPEN_MAX   = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [0:0] cmd_bank = '0;
  logic [3:0] cmd_chan = '0;
  logic       cmd_ready, iss_valid, iss_ract, err_illegal, err_open_long;
  logic [3:0] iss_op;
  logic [0:0] iss_bank;
  logic [3:0] iss_chan;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vc_cmd_guard #(.T_RAS_MAX(OPEN_MAX)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_chan(cmd_chan), .cmd_ready(cmd_ready),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_bank(iss_bank),
    .iss_chan(iss_chan), .iss_ract(iss_ract), .err_illegal(err_illegal),
    .err_open_long(err_open_long)
  );

  // {op[18:15], bank[14], chan[13:10], wait[9:6], kind[5:4], req[3:0]}
  // kind: 0 issued, 1 dropped, 2 issued as restore-activate
  localparam logic [18:0] VEC [0:27] = '{
    {4'd0, 1'b0, 4'd0, 4'd0, 2'd0, 4'd1},  // R1 ACT b0 right after reset
    {4'd0, 1'b1, 4'd0, 4'd1, 2'd0, 4'd7},  // R7 ACT b1, cross-bank gap 2
    {4'd3, 1'b0, 4'd3, 4'd0, 2'd0, 4'd6},  // R6 PFC b0 ch3
    {4'd3, 1'b1, 4'd5, 4'd2, 2'd0, 4'd6},  // R6 PFC b1 ch5, PFC to PFC 3
    {4'd8, 1'b0, 4'd5, 4'd1, 2'd0, 4'd10}, // R10 RD ch5 after PFC ch5
    {4'd9, 1'b0, 4'd3, 4'd0, 2'd0, 4'd10}, // R10 WR ch3
    {4'd1, 1'b1, 4'd0, 4'd0, 2'd0, 4'd5},  // R5 PRE b1
    {4'd1, 1'b0, 4'd0, 4'd0, 2'd0, 4'd5},  // R5 PRE b0
    {4'd0, 1'b0, 4'd0, 4'd2, 2'd0, 4'd4},  // R4 ACT b0, PRE to ACT 3
    {4'd1, 1'b0, 4'd0, 4'd6, 2'd0, 4'd5},  // R5 PRE b0, ACT to PRE 7
    {4'd2, 1'b0, 4'd0, 4'd2, 2'd0, 4'd4},  // R4 REF b0, PRE to REF 3
    {4'd0, 1'b0, 4'd0, 4'd8, 2'd0, 4'd4},  // R4 ACT b0, REF to ACT 9
    {4'd4, 1'b0, 4'd1, 4'd1, 2'd0, 4'd6},  // R6 PFCA b0, ACT to PF 2
    {4'd0, 1'b0, 4'd0, 4'd6, 2'd0, 4'd4},  // R4 ACT b0 after PFCA
    {4'd1, 1'b1, 4'd0, 4'd0, 2'd1, 4'd11}, // R11 PRE to idle b1
    {4'd12, 1'b0, 4'd0, 4'd0, 2'd1, 4'd2}, // R2 unknown code 12
    {4'd6, 1'b1, 4'd7, 4'd0, 2'd0, 4'd8},  // R8 RST b1 ch7
    {4'd8, 1'b0, 4'd7, 4'd0, 2'd1, 4'd9},  // R9 RD to restored ch7
    {4'd3, 1'b0, 4'd2, 4'd0, 2'd1, 4'd9},  // R9 PFC inside window
    {4'd0, 1'b1, 4'd0, 4'd0, 2'd2, 4'd8},  // R8 ACT b1 is restore-activate
    {4'd3, 1'b1, 4'd2, 4'd4, 2'd0, 4'd6},  // R6 PFC b1, ract to PF 5
    {4'd8, 1'b0, 4'd2, 4'd1, 2'd0, 4'd10}, // R10 RD ch2 after PFC ch2
    {4'd1, 1'b1, 4'd0, 4'd0, 2'd0, 4'd5},  // R5 PRE b1 exactly 3 after PFC
    {4'd7, 1'b1, 4'd4, 4'd0, 2'd0, 4'd7},  // R7 RSTA b1 ch4 after PFC
    {4'd0, 1'b1, 4'd0, 4'd1, 2'd2, 4'd8},  // R8 ract stalled inside window
    {4'd8, 1'b0, 4'd9, 4'd0, 2'd0, 4'd10}, // R10 RD ch9 not delayed
    {4'd8, 1'b0, 4'd4, 4'd2, 2'd0, 4'd10}, // R10 RD ch4, ract to RD 4
    {4'd0, 1'b0, 4'd0, 4'd0, 2'd1, 4'd11}  // R11 ACT to open b0
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Offer one command from a negedge; return at the negedge after acceptance.
  task automatic send(input logic [3:0] op, input logic b, input logic [3:0] ch,
                      output int w);
    cmd_op    = op;
    cmd_bank  = b;
    cmd_chan  = ch;
    cmd_valid = 1'b1;
    w = 0;
    #1;
    while (!cmd_ready && w < 64) begin
      @(negedge clk);
      #1;
      w++;
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    #1;
    check(cmd_ready == 1'b0, "R1 ready in reset", cmd_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    check(iss_valid == 0 && err_illegal == 0 && err_open_long == 0,
          "R1 outputs after reset", {iss_valid, err_illegal, err_open_long}, 0);

    // ---- vector table ----
    for (int i = 0; i < 28; i++) begin
      logic [3:0] v_op, v_ch, v_w, v_r;
      logic       v_b;
      logic [1:0] v_k;
      {v_op, v_b, v_ch, v_w, v_k, v_r} = VEC[i];
      send(v_op, v_b, v_ch, w);
      check(w == int'(v_w), $sformatf("R%0d vec%0d stall", v_r, i), w, v_w);
      if (v_k == 2'd1) begin
        check(err_illegal && !iss_valid, $sformatf("R%0d vec%0d drop", v_r, i),
              {iss_valid, err_illegal}, 1);
      end else begin
        check(iss_valid && !err_illegal && iss_op == v_op && iss_bank == v_b &&
              iss_chan == v_ch, $sformatf("R3 vec%0d issue", i),
              {iss_valid, err_illegal, iss_op}, {2'b10, v_op});
        check(iss_ract == (v_k == 2'd2), $sformatf("R%0d vec%0d ract flag", v_r, i),
              iss_ract, (v_k == 2'd2));
      end
    end

    // ---- R8: restore window expires with no activate ----
    send(4'd1, 1'b1, 4'd0, w);
    send(4'd1, 1'b0, 4'd0, w);
    send(4'd6, 1'b0, 4'd1, w);
    check(iss_valid && iss_op == 4'd6, "R8 RST issued", iss_op, 6);
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      check(err_illegal == (k == 5), $sformatf("R8 expiry pulse k=%0d", k),
            err_illegal, (k == 5));
    end
    send(4'd0, 1'b0, 4'd0, w);
    check(iss_valid && !iss_ract, "R8 late ACT is plain", iss_ract, 0);

    // ---- R12: open-time flag ----
    for (int k = 1; k <= 42; k++) begin
      if (k > 1) @(negedge clk);
      if (k >= 40)
        check(err_open_long == (k == 42), $sformatf("R12 open flag k=%0d", k),
              err_open_long, (k == 42));
    end
    send(4'd1, 1'b0, 4'd0, w);
    check(w == 0 && iss_valid, "R12 PRE after long open", w, 0);
    @(negedge clk);
    check(err_open_long == 1'b0, "R12 flag clears", err_open_long, 0);

    // ---- R1: reset mid-run clears bank state and spacing ----
    send(4'd0, 1'b1, 4'd0, w);
    check(iss_valid == 1'b1, "R1 ACT b1 before reset", iss_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(cmd_ready == 1'b0, "R1 ready low in reset", cmd_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    check(!iss_valid && !err_illegal && !err_open_long, "R1 outputs cleared",
          {iss_valid, err_illegal, err_open_long}, 0);
    send(4'd0, 1'b1, 4'd0, w);
    check(w == 0 && iss_valid && !err_illegal, "R1 bank idle after reset",
          {w[3:0], iss_valid}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule